// File: doc/BRIEF.md
# Audio Link Global Control and Status

This block holds the control and status state shared by every DMA channel of an audio codec controller. Software writes one control word to switch the serial link off, to send the codec a timed warm-reset pulse that wakes a sleeping link, or to hold a cold reset. The block drives these as plain level outputs toward the link logic. The warm-reset control bit clears itself when the pulse ends. The cold-reset bit stays set until software clears it.

A read-only status word combines live signals into one view: the ready and resume indications of two codecs, a codec read timeout flag, a general-purpose-input change flag, and the interrupt lines of five DMA channels. The block drives one interrupt output that is the OR of the channel interrupts and of the gated general-purpose-input change. A semaphore word reports busy while a codec register transfer is in flight. The link side marks the start and end of each transfer with single-cycle strobes.

The register port is a plain single-cycle interface. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current state, so it needs no handshake and has no back-pressure. The other pins are level or strobe control and status signals, not data streams.

Top module: `audio_glob_ctl`

## Requirements
- R1: After reset the control word reads 0, the semaphore reads 0, `cold_rst` and `warm_rst` are 0, `link_en` is 1 and `codec_busy` is 0.
- R2: The control word is at address 0x0. Bit 0 enables the GPI interrupt, bit 1 is cold reset and bit 3 is link off. Each of these bits takes the written value at the write edge and holds it until the next write. `cold_rst` equals bit 1 and `link_en` equals the inverse of bit 3.
- R3: Writing 1 to control bit 2 while no pulse runs and while the written bit 1 is 0 drives `warm_rst` high for exactly WARM_CYCLES cycles, starting the cycle after the write. Control bit 2 reads 1 for those cycles and then returns to 0 without a further write.
- R4: While a warm pulse runs, writing bit 2 as 1 does not restart it and writing it as 0 does not cancel it. A write with bit 1 set ends any pulse at that edge and starts none, so `warm_rst` and `cold_rst` are never high together.
- R5: The status word at address 0x4 shows live input values at these bit positions. Bit 0 is GPI change. Bits 1 and 2 are the modem-in and modem-out interrupts. Bits 5, 6 and 7 are the PCM-in, PCM-out and mic-in interrupts. Bits 8 and 9 are primary and secondary codec ready. Bits 10 and 11 are primary and secondary resume. Bit 15 is the codec read timeout. All other bits read 0. The `chan_irq` index order is 0 mic-in, 1 PCM-out, 2 PCM-in, 3 modem-out and 4 modem-in.
- R6: Writes to the status address (0x4), the semaphore address (0x8) or any unmapped address change no state. Unmapped addresses read 0.
- R7: Semaphore bit 0 at address 0x8 and `codec_busy` are 1 from the cycle after `acc_start` until the cycle after `acc_done`. When both strobes arrive together the result is busy. While cold reset is held, busy is cleared and `acc_start` is ignored.
- R8: `irq` is combinationally the OR of all `chan_irq` lines and of `gpi_change` gated by control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| chan_irq | input | NUM_CH | Channel interrupt lines |
| codec_rdy | input | 2 | Codec ready, index 0 primary, 1 secondary |
| codec_resume | input | 2 | Codec resume, index 0 primary, 1 secondary |
| rd_timeout | input | 1 | Codec read timed out |
| gpi_change | input | 1 | General-purpose inputs changed |
| acc_start | input | 1 | Codec register transfer begins (strobe) |
| acc_done | input | 1 | Codec register transfer ends (strobe) |
| cold_rst | output | 1 | Cold reset to codec, level |
| warm_rst | output | 1 | Warm reset pulse to link |
| link_en | output | 1 | Serial link enabled |
| codec_busy | output | 1 | Codec register transfer in flight |
| irq | output | 1 | Summary interrupt |

## Verification
The assertions check three things on every cycle. A warm pulse never overlaps a cold reset. A running pulse continues until its count runs out and then stops. The cold-reset bit, the semaphore and the interrupt follow their strobes and levels. Some behaviour can be shown only by the bench's scenarios: the exact pulse length and its start cycle, that a repeated or zero write neither restarts nor cancels a pulse, the bit placement of each live status source, and that writes to read-only or unmapped addresses leave no trace. The bench compares every output and the read data against a behavioural model on every clock. It runs directed sequences and then a long run of random inputs and writes.

// File: rtl/agc_pkg.sv
package agc_pkg;
  // register byte addresses
  localparam int ADR_CTRL = 'h0;
  localparam int ADR_STAT = 'h4;
  localparam int ADR_SEMA = 'h8;

  // control word fields
  localparam int CB_GPI_IE   = 0;
  localparam int CB_COLD     = 1;
  localparam int CB_WARM     = 2;
  localparam int CB_LINK_OFF = 3;
  localparam int CTRL_BITS   = 4;

  // status word fields
  localparam int SB_GPI      = 0;
  localparam int SB_MODEM_IN = 1;
  localparam int SB_MODEM_OUT= 2;
  localparam int SB_PCM_IN   = 5;
  localparam int SB_PCM_OUT  = 6;
  localparam int SB_MIC_IN   = 7;
  localparam int SB_PRI_RDY  = 8;
  localparam int SB_SEC_RDY  = 9;
  localparam int SB_PRI_RES  = 10;
  localparam int SB_SEC_RES  = 11;
  localparam int SB_RD_TMO   = 15;
  localparam int STAT_BITS   = 16;

  localparam int NUM_CH = 5;

  // status position of each channel interrupt line
  function automatic int chan_pos(input int idx);
    case (idx)
      0:       return SB_MIC_IN;
      1:       return SB_PCM_OUT;
      2:       return SB_PCM_IN;
      3:       return SB_MODEM_OUT;
      default: return SB_MODEM_IN;
    endcase
  endfunction

  typedef struct packed {
    logic link_off;
    logic cold;
    logic gpi_ie;
  } ctrl_t;
endpackage

// File: rtl/agc_ctrl_reg.sv
module agc_ctrl_reg
  import agc_pkg::*;
#(
  parameter int WARM_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CTRL_BITS-1:0] wdata,
  output ctrl_t                ctrl,
  output logic                 warm_active,
  output logic [CTRL_BITS-1:0] ctrl_word
);
  localparam int CW = $clog2(WARM_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WARM_CYCLES);

  ctrl_t         ctrl_q;
  logic [CW-1:0] cnt;
  logic          abort, start;

  assign abort = wr_en && wdata[CB_COLD];
  assign start = wr_en && wdata[CB_WARM] && !wdata[CB_COLD] && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.gpi_ie   <= wdata[CB_GPI_IE];
      ctrl_q.cold     <= wdata[CB_COLD];
      ctrl_q.link_off <= wdata[CB_LINK_OFF];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (abort)       cnt <= '0;
    else if (start)       cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign warm_active = (cnt != '0);
  assign ctrl        = ctrl_q;

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CB_GPI_IE]   = ctrl_q.gpi_ie;
    ctrl_word[CB_COLD]     = ctrl_q.cold;
    ctrl_word[CB_WARM]     = warm_active;
    ctrl_word[CB_LINK_OFF] = ctrl_q.link_off;
  end

  // R3
  warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CW'(1) && !abort) |=> warm_active);
  // R3
  warm_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(1)) |=> !warm_active);
  // R4
  warm_cold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_active |-> !ctrl_q.cold);
  // R2
  cold_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q.cold));
endmodule

// File: rtl/agc_sema.sv
module agc_sema (
  input  logic clk,
  input  logic rst_n,
  input  logic cold,
  input  logic acc_start,
  input  logic acc_done,
  output logic busy
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_q <= 1'b0;
    else if (cold)       busy_q <= 1'b0;
    else if (acc_start)  busy_q <= 1'b1;
    else if (acc_done)   busy_q <= 1'b0;
  end

  assign busy = busy_q;

  // R7
  sema_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !cold) |=> busy);
  // R7
  sema_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !acc_start) |=> !busy);
  // R7
  sema_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cold |=> !busy);
endmodule

// File: rtl/agc_status.sv
module agc_status
  import agc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    chan_irq,
  input  logic [1:0]           codec_rdy,
  input  logic [1:0]           codec_resume,
  input  logic                 rd_timeout,
  input  logic                 gpi_change,
  input  logic                 gpi_ie,
  output logic [STAT_BITS-1:0] stat_word,
  output logic                 irq
);
  always_comb begin
    stat_word             = '0;
    stat_word[SB_GPI]     = gpi_change;
    for (int i = 0; i < NUM_CH; i++)
      stat_word[chan_pos(i)] = chan_irq[i];
    stat_word[SB_PRI_RDY] = codec_rdy[0];
    stat_word[SB_SEC_RDY] = codec_rdy[1];
    stat_word[SB_PRI_RES] = codec_resume[0];
    stat_word[SB_SEC_RES] = codec_resume[1];
    stat_word[SB_RD_TMO]  = rd_timeout;
  end

  assign irq = (|chan_irq) | (gpi_ie & gpi_change);

  // R8
  irq_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_irq) |-> irq);
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq == '0 && !gpi_change) |-> !irq);
endmodule

// File: rtl/audio_glob_ctl.sv
module audio_glob_ctl
  import agc_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int WARM_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] chan_irq,
  input  logic [1:0]        codec_rdy,
  input  logic [1:0]        codec_resume,
  input  logic              rd_timeout,
  input  logic              gpi_change,
  input  logic              acc_start,
  input  logic              acc_done,
  output logic              cold_rst,
  output logic              warm_rst,
  output logic              link_en,
  output logic              codec_busy,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_SEMA = ADDR_W'(ADR_SEMA);

  ctrl_t                ctrl;
  logic                 warm_active, busy, ctrl_wr;
  logic [CTRL_BITS-1:0] ctrl_word;
  logic [STAT_BITS-1:0] stat_word;
  logic                 unused_wdata;

  assign ctrl_wr      = reg_wr && (reg_addr == A_CTRL);
  assign unused_wdata = ^reg_wdata[DATA_W-1:CTRL_BITS];

  agc_ctrl_reg #(.WARM_CYCLES(WARM_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ctrl_wr),
    .wdata      (reg_wdata[CTRL_BITS-1:0]),
    .ctrl       (ctrl),
    .warm_active(warm_active),
    .ctrl_word  (ctrl_word)
  );

  agc_sema u_sema (
    .clk      (clk),
    .rst_n    (rst_n),
    .cold     (ctrl.cold),
    .acc_start(acc_start),
    .acc_done (acc_done),
    .busy     (busy)
  );

  agc_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_irq    (chan_irq),
    .codec_rdy   (codec_rdy),
    .codec_resume(codec_resume),
    .rd_timeout  (rd_timeout),
    .gpi_change  (gpi_change),
    .gpi_ie      (ctrl.gpi_ie),
    .stat_word   (stat_word),
    .irq         (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = DATA_W'(ctrl_word);
      A_STAT:  reg_rdata = DATA_W'(stat_word);
      A_SEMA:  reg_rdata = DATA_W'(busy);
      default: reg_rdata = '0;
    endcase
  end

  assign cold_rst   = ctrl.cold;
  assign warm_rst   = warm_active;
  assign link_en    = !ctrl.link_off;
  assign codec_busy = busy;

  // R6
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != A_CTRL) |=> ($stable(cold_rst) && $stable(link_en)));
endmodule

// File: tb/test_audio_glob_ctl.sv
module test_audio_glob_ctl;
  localparam int W = 5;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [4:0]  chan_irq = 0;
  logic [1:0]  codec_rdy = 0, codec_resume = 0;
  logic        rd_timeout = 0, gpi_change = 0, acc_start = 0, acc_done = 0;
  logic        cold_rst, warm_rst, link_en, codec_busy, irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  bit m_gie, m_cold, m_off, m_busy;
  int m_left;

  always #5 clk = ~clk;

  audio_glob_ctl #(.ADDR_W(4), .DATA_W(32), .WARM_CYCLES(W)) i_audio_glob_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_irq(chan_irq),
    .codec_rdy(codec_rdy), .codec_resume(codec_resume), .rd_timeout(rd_timeout),
    .gpi_change(gpi_change), .acc_start(acc_start), .acc_done(acc_done),
    .cold_rst(cold_rst), .warm_rst(warm_rst), .link_en(link_en),
    .codec_busy(codec_busy), .irq(irq));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gie = 0; m_cold = 0; m_off = 0; m_busy = 0; m_left = 0;
    end else begin
      bit wc;
      wc = reg_wr && reg_addr == 4'h0;
      // semaphore uses the cold level present before this edge
      if (m_cold) m_busy = 0;
      else if (acc_start) m_busy = 1;
      else if (acc_done) m_busy = 0;
      if (wc && reg_wdata[1]) m_left = 0;
      else if (wc && reg_wdata[2] && m_left == 0) m_left = W;
      else if (m_left > 0) m_left--;
      if (wc) begin
        m_gie = reg_wdata[0]; m_cold = reg_wdata[1]; m_off = reg_wdata[3];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = 0;
    s[0] = gpi_change; s[7] = chan_irq[0]; s[6] = chan_irq[1]; s[5] = chan_irq[2];
    s[2] = chan_irq[3]; s[1] = chan_irq[4];
    s[8] = codec_rdy[0]; s[9] = codec_rdy[1];
    s[10] = codec_resume[0]; s[11] = codec_resume[1]; s[15] = rd_timeout;
    return s;
  endfunction

  task automatic compare();
    logic [31:0] e;
    chk(cold_rst === m_cold, "R2 cold_rst", 32'(cold_rst), 32'(m_cold));
    chk(link_en === !m_off, "R2 link_en", 32'(link_en), 32'(!m_off));
    chk(warm_rst === (m_left > 0), "R3 warm_rst", 32'(warm_rst), 32'(m_left > 0));
    chk(codec_busy === m_busy, "R7 codec_busy", 32'(codec_busy), 32'(m_busy));
    e = 32'((|chan_irq) | (m_gie & gpi_change));
    chk(irq === e[0], "R8 irq", 32'(irq), e);
    case (reg_addr)
      4'h0: begin e = {28'd0, m_off, m_left > 0, m_cold, m_gie};
                  chk(reg_rdata === e, "R4 ctrl word", reg_rdata, e); end
      4'h4: begin e = exp_stat(); chk(reg_rdata === e, "R5 status word", reg_rdata, e); end
      4'h8: begin e = 32'(m_busy); chk(reg_rdata === e, "R7 sema word", reg_rdata, e); end
      default: chk(reg_rdata === 0, "R6 unmapped read", reg_rdata, 0);
    endcase
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0; reg_addr = 4'h0;
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cold_rst === 0 && warm_rst === 0 && link_en === 1 && codec_busy === 0,
        "R1 reset outputs", {cold_rst, warm_rst, link_en, codec_busy}, 4'b0010);
    reg_addr = 4'h0; #1;
    chk(reg_rdata === 0, "R1 ctrl after reset", reg_rdata, 0);
    reg_addr = 4'h8; #1;
    chk(reg_rdata === 0, "R1 sema after reset", reg_rdata, 0);
    reg_addr = 4'h0;
    rst_n = 1;
    tick();

    // R2 / R8: gpi enable gating and link off
    gpi_change = 1; tick();
    wr(4'h0, 32'h1); tick();
    gpi_change = 0; tick();
    wr(4'h0, 32'h9); tick(); tick();
    wr(4'h0, 32'h0); tick();

    // R3 warm pulse, R4 rewrite and zero write during pulse
    wr(4'h0, 32'h4);
    tick();
    wr(4'h0, 32'h4);
    wr(4'h0, 32'h0);
    repeat (W + 2) tick();
    // R4 cold write aborts a running pulse
    wr(4'h0, 32'h4); tick();
    wr(4'h0, 32'h2); repeat (3) tick();
    wr(4'h0, 32'h6); repeat (2) tick();
    wr(4'h0, 32'h0); tick();

    // R7 semaphore
    acc_start = 1; tick(); acc_start = 0; repeat (3) tick();
    acc_done = 1; tick(); acc_done = 0; tick();
    acc_start = 1; acc_done = 1; tick(); acc_start = 0; acc_done = 0; tick();
    wr(4'h0, 32'h2);
    acc_start = 1; tick(); tick(); acc_start = 0;
    wr(4'h0, 32'h0); tick();

    // R5 / R6 status placement, read-only and unmapped writes
    chan_irq = 5'b10101; codec_rdy = 2'b01; codec_resume = 2'b10; rd_timeout = 1;
    reg_addr = 4'h4; tick();
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    reg_addr = 4'h4; tick();
    reg_addr = 4'hC; tick();
    reg_addr = 4'h0; tick();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom;
      chan_irq = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      codec_rdy = 2'($urandom); codec_resume = 2'($urandom);
      rd_timeout = ($urandom % 8 == 0); gpi_change = ($urandom % 3 == 0);
      acc_start = ($urandom % 10 == 0); acc_done = ($urandom % 6 == 0);
      reg_addr = 4'(($urandom % 4) * 4) | 4'((r % 23 == 0) ? 1 : 0);
      reg_wr = ($urandom % 12 == 0);
      reg_wdata = $urandom;
      if (reg_wr && reg_wdata[1]) reg_wdata[1] = ($urandom % 3 == 0);
      tick();
    end
    reg_wr = 0; tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule